// File: doc/BRIEF.md
# Hardware-capped advertisement register

This block holds the 16-bit ability word that a twisted-pair link controller offers to its partner during speed and duplex negotiation. Four ability bits describe the 100 Mb/s and 10 Mb/s technologies, each at full and half duplex. Their starting value comes from a 3-bit technology strap that is sampled while the block leaves reset. That strap value also becomes a permanent ceiling for the rest of the session.

Software reaches the word through a plain write strobe with a data bus, and reads it back on the same output that feeds the negotiation controller. A write can drop any ability and later restore it. A write can never switch on an ability that the strap ceiling withholds, so the hardware configuration always wins. The lowest five bits carry the fixed protocol selector. The bits above the ability field always read as zero. Every accepted write raises a one-cycle update flag, which the negotiation controller uses to restart.

Top module: `adv_cap_reg`

## Requirements
- R1: While `rst_n` is low, `adv_word` reads 16'h0001 and `adv_update` is 0. Two clock edges after `rst_n` rises, `adv_word` holds the strap-decoded abilities in bits 8:5 and 00001 in bits 4:0.
- R2: The ability field is bit 8 = 100 Mb/s full, bit 7 = 100 Mb/s half, bit 6 = 10 Mb/s full and bit 5 = 10 Mb/s half. The strap codes decode as follows: 0 = all four, 1 = 10 half, 2 = 10 full and 10 half, 3 = 100 half, 4 = 100 full and 100 half, 5 = 100 half and 10 half, 6 = all except 100 full, 7 = all four.
- R3: The ceiling is latched at reset release. Later changes of `strap_tech` have no effect on `adv_word` or on what a write can set.
- R4: A write (`wr_en` high at a rising edge after release) stores `wr_data[8:5]` AND the ceiling into bits 8:5. The new value is visible from that edge on.
- R5: An ability bit inside the ceiling can be written to 0 and then back to 1.
- R6: An ability bit outside the ceiling stays 0 whatever is written.
- R7: Bits 4:0 always read 00001 and bits 15:9 always read 0. The corresponding bits of `wr_data` are ignored.
- R8: `adv_update` is high for exactly the one cycle after each accepted write, including a write that leaves the value unchanged. It is low otherwise.
- R9: A write presented during the two cycles between the rise of `rst_n` and release is ignored. It changes no bits and raises no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_tech | input | 3 | Technology strap, latched at reset release |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| adv_word | output | 16 | Current advertisement word (read data and negotiation feed) |
| adv_update | output | 1 | One-cycle pulse after each accepted write |

## Verification
The hardest case to reach from the ports is a write that arrives during the short window after `rst_n` rises but before the internal reset releases. In that window the strap is still being loaded, and an accepted write would corrupt the power-up word. The bench raises `rst_n` on a falling edge and holds `wr_en` with all-zero data across exactly the next two rising edges. It then checks that the strap-derived word is intact and that no update pulse appeared. A second hard case is a strap change after release; the bench changes the strap and follows it with an all-ones write to expose any leak.

// File: rtl/adv_cap_pkg.sv
package adv_cap_pkg;

  localparam int ABIL_W = 4;
  localparam int TECH_W = 3;

  // bit0: 10 half, bit1: 10 full, bit2: 100 half, bit3: 100 full
  typedef logic [ABIL_W-1:0] abil_t;

  typedef enum logic [TECH_W-1:0] {
    TECH_DEFAULT  = 3'd0,
    TECH_10H      = 3'd1,
    TECH_10HF     = 3'd2,
    TECH_TXH      = 3'd3,
    TECH_TXHF     = 3'd4,
    TECH_TXH_10H  = 3'd5,
    TECH_NO_TXF   = 3'd6,
    TECH_ALL      = 3'd7
  } tech_e;

  function automatic abil_t tech_to_abil(input logic [TECH_W-1:0] code);
    abil_t a;
    case (tech_e'(code))
      TECH_DEFAULT: a = 4'b1111;
      TECH_10H:     a = 4'b0001;
      TECH_10HF:    a = 4'b0011;
      TECH_TXH:     a = 4'b0100;
      TECH_TXHF:    a = 4'b1100;
      TECH_TXH_10H: a = 4'b0101;
      TECH_NO_TXF:  a = 4'b0111;
      default:      a = 4'b1111;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/adv_rst_sync.sv
module adv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/adv_strap_limit.sv
module adv_strap_limit
  import adv_cap_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ABIL_LSB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TECH_W-1:0] strap_tech,
  output abil_t             limit_q,
  output logic [DATA_W-1:0] cap_mask,
  output logic [DATA_W-1:0] strap_mask
);

  abil_t strap_abil;
  abil_t limit_d;

  always_comb strap_abil = tech_to_abil(strap_tech);

  // capture enable: follow the strap while the internal reset is held
  always_comb begin
    limit_d = limit_q;
    if (load) begin
      limit_d = strap_abil;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else begin
      limit_q <= limit_d;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i >= ABIL_LSB && i < ABIL_LSB + ABIL_W) begin : g_abil
      assign cap_mask[i]   = limit_q[i-ABIL_LSB];
      assign strap_mask[i] = strap_abil[i-ABIL_LSB];
    end else begin : g_fixed
      assign cap_mask[i]   = 1'b0;
      assign strap_mask[i] = 1'b0;
    end
  end

endmodule

// File: rtl/adv_word_reg.sv
module adv_word_reg #(
  parameter int              DATA_W   = 16,
  parameter int              SEL_W    = 5,
  parameter logic [SEL_W-1:0] SEL_CODE = 5'b00001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] cap_mask,
  input  logic [DATA_W-1:0] strap_mask,
  output logic [DATA_W-1:0] word_q,
  output logic              upd_q
);

  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(SEL_CODE);

  logic [DATA_W-1:0] word_d;
  logic              upd_d;
  logic              wr_accept;

  always_comb wr_accept = wr_en & ~load;

  always_comb begin
    word_d = word_q;
    if (load) begin
      word_d = strap_mask | SEL_MASK;
    end else if (wr_accept) begin
      word_d = (wr_data & cap_mask) | SEL_MASK;
    end
  end

  always_comb upd_d = wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= SEL_MASK;
      upd_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      upd_q  <= upd_d;
    end
  end

endmodule

// File: rtl/adv_cap_reg.sv
module adv_cap_reg
  import adv_cap_pkg::*;
#(
  parameter int               DATA_W      = 16,
  parameter int               SEL_W       = 5,
  parameter logic [SEL_W-1:0] SEL_CODE    = 5'b00001,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TECH_W-1:0] strap_tech,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] adv_word,
  output logic              adv_update
);

  localparam int ABIL_LSB = SEL_W;

  logic              rst_sync_n;
  logic              load;
  abil_t             limit_q;
  logic [DATA_W-1:0] cap_mask;
  logic [DATA_W-1:0] strap_mask;

  adv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign load = ~rst_sync_n;

  adv_strap_limit #(.DATA_W(DATA_W), .ABIL_LSB(ABIL_LSB)) u_limit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .strap_tech (strap_tech),
    .limit_q    (limit_q),
    .cap_mask   (cap_mask),
    .strap_mask (strap_mask)
  );

  adv_word_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_CODE(SEL_CODE)) u_word (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .cap_mask   (cap_mask),
    .strap_mask (strap_mask),
    .word_q     (adv_word),
    .upd_q      (adv_update)
  );

endmodule

// File: rtl/adv_cap_reg_chk.sv
module adv_cap_reg_chk
  import adv_cap_pkg::*;
#(
  parameter int               DATA_W   = 16,
  parameter int               SEL_W    = 5,
  parameter logic [SEL_W-1:0] SEL_CODE = 5'b00001
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input abil_t             limit_q,
  input logic [DATA_W-1:0] adv_word,
  input logic              adv_update
);

  localparam int                ABIL_LSB  = SEL_W;
  localparam logic [DATA_W-1:0] ABIL_BITS = DATA_W'({ABIL_W{1'b1}}) << ABIL_LSB;

  // R6
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sync_n |-> ((abil_t'(adv_word >> ABIL_LSB) & ~limit_q) == '0));

  // R4
  write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && wr_en) |=>
      (abil_t'(adv_word >> ABIL_LSB) == (abil_t'($past(wr_data) >> ABIL_LSB) & limit_q)));

  // R8
  update_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && wr_en) |=> adv_update);

  // R9
  update_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_sync_n && wr_en) |=> !adv_update);

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !wr_en) |=> $stable(adv_word));

  // R3
  limit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sync_n |=> $stable(limit_q));

  // R7
  fields_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sync_n |-> ((adv_word & ~ABIL_BITS) == DATA_W'(SEL_CODE)));

endmodule

bind adv_cap_reg adv_cap_reg_chk #(
  .DATA_W   (DATA_W),
  .SEL_W    (SEL_W),
  .SEL_CODE (SEL_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .limit_q    (limit_q),
  .adv_word   (adv_word),
  .adv_update (adv_update)
);

// File: tb/sim_adv_cap_reg.sv
`timescale 1ns/1ps
module sim_adv_cap_reg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  strap;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] adv_word;
  logic        adv_update;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  adv_cap_reg u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_tech (strap),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .adv_word   (adv_word),
    .adv_update (adv_update)
  );

  // {100F, 100H, 10F, 10H} per strap code
  function automatic logic [3:0] cap_of(input logic [2:0] t);
    case (t)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0100;
      3'd4:    return 4'b1100;
      3'd5:    return 4'b0101;
      3'd6:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [15:0] word_of(input logic [3:0] a);
    return {7'b0, a, 5'b00001};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [2:0] t);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; strap = t;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic write(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; strap = 3'd5;
    repeat (2) @(negedge clk);
    chk("R1 word in reset", adv_word, 16'h0001);
    chk("R1 update in reset", {15'b0, adv_update}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 word after release", adv_word, word_of(cap_of(3'd5)));
  endtask

  task automatic t_strap_table();
    for (int t = 0; t < 8; t++) begin
      apply_reset(3'(t));
      chk($sformatf("R2 strap %0d", t), adv_word, word_of(cap_of(3'(t))));
    end
  endtask

  task automatic t_capped_write();
    apply_reset(3'd4);
    write(16'hFFFF);
    chk("R4 all-ones write", adv_word, 16'h0181);
    chk("R8 pulse after write", {15'b0, adv_update}, 16'h1);
    @(negedge clk);
    chk("R8 pulse ends", {15'b0, adv_update}, 16'h0);
    write(16'h0080);
    chk("R4 partial write", adv_word, 16'h0081);
  endtask

  task automatic t_clear_restore();
    apply_reset(3'd0);
    write(16'h0000);
    chk("R5 cleared", adv_word, 16'h0001);
    write(16'h0060);
    chk("R5 10M restored", adv_word, 16'h0061);
    write(16'h01E0);
    chk("R5 all restored", adv_word, 16'h01E1);
  endtask

  task automatic t_no_grant();
    apply_reset(3'd1);
    write(16'h0000);
    write(16'h01E0);
    chk("R6 no grant above ceiling", adv_word, 16'h0021);
  endtask

  task automatic t_fields();
    apply_reset(3'd7);
    write(16'hFE1E);
    chk("R7 reserved and selector ignored", adv_word, 16'h0001);
    write(16'hFFFF);
    chk("R7 fixed fields on all-ones", adv_word, 16'h01E1);
  endtask

  task automatic t_strap_ignored();
    apply_reset(3'd3);
    strap = 3'd7;
    repeat (3) @(negedge clk);
    chk("R3 word after strap change", adv_word, 16'h0081);
    write(16'hFFFF);
    chk("R3 ceiling after strap change", adv_word, 16'h0081);
  endtask

  task automatic t_update_repeat();
    apply_reset(3'd2);
    write(16'h0060);
    chk("R8 first write value", adv_word, 16'h0061);
    write(16'h0060);
    chk("R8 pulse on unchanged write", {15'b0, adv_update}, 16'h1);
    @(negedge clk);
    chk("R8 idle no pulse", {15'b0, adv_update}, 16'h0);
    @(negedge clk);
    chk("R8 idle word held", adv_word, 16'h0061);
  endtask

  task automatic t_early_write();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; strap = 3'd6;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr_en = 1'b1; wr_data = 16'h0000;
    repeat (2) @(negedge clk);
    wr_en = 1'b0;
    chk("R9 early write no pulse", {15'b0, adv_update}, 16'h0);
    chk("R9 early write ignored", adv_word, 16'h00E1);
    @(negedge clk);
    chk("R9 still no pulse", {15'b0, adv_update}, 16'h0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_strap_table();
    t_capped_write();
    t_clear_restore();
    t_no_grant();
    t_fields();
    t_strap_ignored();
    t_update_repeat();
    t_early_write();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule